// File: doc/BRIEF.md
# Two-Level Interrupt Register Aggregator

This block collects interrupt events from several leaf groups and combines them into one master register that drives a host interrupt pulse. Each leaf group has four 32-bit registers on a simple register bus: a raw status view, a mask, a sticky identity register and an enable. An unmasked event sets its identity bit. The bit stays set until software clears it by writing a 1 to it.

Each leaf's pending value is its identity bits ANDed with its enable bits. A fixed routing table turns each leaf's pending value into master summary bits. The table can split one leaf into several bit-range masks. By default, the lower half of leaf 0 drives master bit 0 and its upper half drives master bit 1. Every other leaf k drives master bit 15+k through all 32 of its bits. Bit 31 of the master register is the global delivery switch and is the only bit software can write there.

When the switch is on and any summary bit is set, the block emits a one-cycle pulse toward the host. The pulse fires when that condition begins, and fires again for each newly latched event while the condition continues.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every identity, enable and status register reads 0, every mask register reads 0xFFFFFFFF, the master register reads 0 and irq_o stays low.
- R2: An event bit sets the matching identity bit at the next clock edge only if that leaf's mask bit is 0. A masked event leaves the identity register unchanged.
- R3: A write to a leaf's identity register (offset 0x8) clears exactly the bits written as 1 and keeps the others. An event arriving in the same cycle as the write sets its bit anyway.
- R4: A leaf's status register (offset 0x0) returns the raw event inputs sampled at the previous edge, whatever the mask holds.
- R5: Master bit 0 is set exactly when (identity AND enable AND 0x0000FFFF) of leaf 0 is nonzero. Master bit 1 is set the same way for the mask 0xFFFF0000. Master bit 15+k is set exactly when (identity AND enable) of leaf k (k >= 1) is nonzero.
- R6: A write to the master register (address 0x100) changes only bit 31, the delivery switch. The written value of every other bit is ignored, and the summary bits keep their values.
- R7: irq_o pulses for one cycle in the cycle in which the switch is set and at least one summary bit is set, when that was not the case the cycle before.
- R8: While the delivery condition holds, irq_o pulses once for each cycle in which any unmasked event arrives. A change to the enable or master register alone does not pulse it again.
- R9: While bit 31 of the master register is 0, irq_o stays low whatever the summary bits are.
- R10: Read data appears on rdata_o in the cycle after rd_en_i and is 0 otherwise. Master bits with no routing entry read 0, and addresses outside the leaf windows and the master address read 0.
- R11: A write to a leaf's enable register (offset 0xC) or identity register updates the master summary bits at the same clock edge that updates the written register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address; leaf k at 0x10*k, master at MASTER_ADDR |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| evt_i | input | NUM_LEAF*32 | Event inputs, leaf k in bits [32k+31:32k] |
| irq_o | output | 1 | One-cycle host interrupt pulse |

## Verification
The routing is exercised with events in both halves of leaf 0 under a half-width enable. This shows whether the split masks feed separate master bits or a single OR. Events are applied with the mask fully set, then cleared, and the status register is read while an event is held. These patterns separate the raw status view from the masked sticky latch. The interrupt count is followed across several steps: the switch turning on, enable widening with no new event, a new event during an active condition, an event coinciding with a clear, and a second leaf raising the condition again. Each step tells edge-triggered delivery apart from level delivery and from re-delivery on every register write. Write-then-read sequences on consecutive cycles confirm that the summary bits follow an enable or identity write at the same edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned CTRL_BIT = 31;
    localparam int unsigned HALF_W   = REG_W / 2;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_IDENT  = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] ident;
        logic [REG_W-1:0] enable;
    } leaf_regs_t;

    typedef struct packed {
        logic             ctrl;
        logic [REG_W-1:0] summary;
        logic             cond;
        logic             irq;
        logic [REG_W-1:0] rdata;
    } top_state_t;

    // Routing table: entries 0 and 1 split leaf 0, entry e >= 2 covers leaf e-1.
    function automatic int map_leaf(input int e);
        return (e < 2) ? 0 : e - 1;
    endfunction

    function automatic logic [REG_W-1:0] map_mask(input int e);
        logic [REG_W-1:0] lo;
        lo = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        if (e == 0)      return lo;
        else if (e == 1) return ~lo;
        else             return '1;
    endfunction

    function automatic int map_bit(input int e);
        return (e < 2) ? e : 14 + e;
    endfunction

endpackage

// File: rtl/irq_leaf.sv
module irq_leaf
    import irq_agg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [REG_W-1:0] evt_i,
    input  logic             wr_en_i,
    input  reg_sel_e         sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] mask_o,
    output logic [REG_W-1:0] ident_o,
    output logic [REG_W-1:0] enable_o,
    output logic [REG_W-1:0] pending_d_o,
    output logic             fresh_o
);

    leaf_regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.status = evt_i;
        if (wr_en_i) begin
            case (sel_i)
                SEL_MASK:   s_d.mask   = wdata_i;
                SEL_IDENT:  s_d.ident  = s_q.ident & ~wdata_i;
                SEL_ENABLE: s_d.enable = wdata_i;
                default:    ;
            endcase
        end
        s_d.ident = s_d.ident | (evt_i & ~s_q.mask);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.status <= '0;
            s_q.mask   <= '1;
            s_q.ident  <= '0;
            s_q.enable <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o    = s_q.status;
    assign mask_o      = s_q.mask;
    assign ident_o     = s_q.ident;
    assign enable_o    = s_q.enable;
    assign pending_d_o = s_d.ident & s_d.enable;
    assign fresh_o     = |(evt_i & ~s_q.mask);

    AST_MASKED_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        ((s_q.ident & ~$past(s_q.ident) & ~($past(evt_i) & ~$past(s_q.mask))) == '0)); // R2

    AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && sel_i == SEL_IDENT) |=>
        ((s_q.ident & $past(wdata_i) & ~($past(evt_i) & ~$past(s_q.mask))) == '0)); // R3

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_LEAF = 4
) (
    input  logic [REG_W-1:0] pending_i [NUM_LEAF],
    output logic [REG_W-1:0] summary_o
);

    localparam int unsigned MAP_CNT = NUM_LEAF + 1;

    logic [MAP_CNT-1:0] hit;

    for (genvar e = 0; e < MAP_CNT; e++) begin : g_entry
        assign hit[e] = |(pending_i[map_leaf(e)] & map_mask(e));
    end

    always_comb begin
        summary_o = '0;
        for (int e = 0; e < MAP_CNT; e++) begin
            if (hit[e]) summary_o[map_bit(e)] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned      NUM_LEAF    = 4,
    parameter int unsigned      ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] MASTER_ADDR = 'h100
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    input  logic [NUM_LEAF*REG_W-1:0] evt_i,
    output logic                      irq_o
);

    localparam int unsigned IDX_W = (NUM_LEAF > 1) ? $clog2(NUM_LEAF) : 1;

    logic [ADDR_W-5:0] slot;
    logic              is_master;
    logic              in_leaf;
    logic [IDX_W-1:0]  leaf_idx;
    reg_sel_e          sel;
    logic              unused_addr;

    assign slot        = addr_i[ADDR_W-1:4];
    assign is_master   = (addr_i == MASTER_ADDR);
    assign in_leaf     = !is_master && (int'(slot) < int'(NUM_LEAF));
    assign leaf_idx    = slot[IDX_W-1:0];
    assign sel         = reg_sel_e'(addr_i[3:2]);
    assign unused_addr = ^addr_i[1:0];

    logic [REG_W-1:0]    lf_status  [NUM_LEAF];
    logic [REG_W-1:0]    lf_mask    [NUM_LEAF];
    logic [REG_W-1:0]    lf_ident   [NUM_LEAF];
    logic [REG_W-1:0]    lf_enable  [NUM_LEAF];
    logic [REG_W-1:0]    lf_pend_d  [NUM_LEAF];
    logic [NUM_LEAF-1:0] lf_fresh;

    for (genvar k = 0; k < NUM_LEAF; k++) begin : g_leaf
        logic leaf_wr;
        assign leaf_wr = wr_en_i && in_leaf && (int'(slot) == k);

        irq_leaf u_leaf (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .evt_i       (evt_i[k*REG_W +: REG_W]),
            .wr_en_i     (leaf_wr),
            .sel_i       (sel),
            .wdata_i     (wdata_i),
            .status_o    (lf_status[k]),
            .mask_o      (lf_mask[k]),
            .ident_o     (lf_ident[k]),
            .enable_o    (lf_enable[k]),
            .pending_d_o (lf_pend_d[k]),
            .fresh_o     (lf_fresh[k])
        );
    end

    logic [REG_W-1:0] sum_d;

    irq_summary #(.NUM_LEAF(NUM_LEAF)) u_summary (
        .pending_i (lf_pend_d),
        .summary_o (sum_d)
    );

    top_state_t t_d, t_q;
    logic [REG_W-1:0] master_view;

    always_comb begin
        master_view           = t_q.summary;
        master_view[CTRL_BIT] = t_q.ctrl;
    end

    always_comb begin
        t_d = t_q;
        if (wr_en_i && is_master) t_d.ctrl = wdata_i[CTRL_BIT];
        t_d.summary           = sum_d;
        t_d.summary[CTRL_BIT] = 1'b0;
        t_d.cond              = t_d.ctrl && (t_d.summary != '0);
        t_d.irq               = t_d.cond && (!t_q.cond || (lf_fresh != '0));
        t_d.rdata             = '0;
        if (rd_en_i) begin
            if (is_master) begin
                t_d.rdata = master_view;
            end else if (in_leaf) begin
                case (sel)
                    SEL_STATUS: t_d.rdata = lf_status[leaf_idx];
                    SEL_MASK:   t_d.rdata = lf_mask[leaf_idx];
                    SEL_IDENT:  t_d.rdata = lf_ident[leaf_idx];
                    default:    t_d.rdata = lf_enable[leaf_idx];
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) t_q <= '0;
        else       t_q <= t_d;
    end

    assign rdata_o = t_q.rdata;
    assign irq_o   = t_q.irq;

    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> t_q.ctrl); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (t_q.summary != '0)); // R7

    AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && is_master) |=> $stable(t_q.ctrl)); // R6

    AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> (rdata_o == '0)); // R10

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    localparam int NL = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [11:0]      addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [NL*32-1:0] evt = '0;
    logic             irq;

    always #2 clk = ~clk;

    irq_aggregator u0 (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .evt_i   (evt),
        .irq_o   (irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    int   irq_cnt = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;

    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: pop the expected read value and compare.
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (rd_seen) begin
            n_vec++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rdata !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.req, rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        sb_q.push_back('{exp: e, req: r});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Write, then read on the very next cycle.
    task automatic wr_rd(input logic [11:0] a, input logic [31:0] d,
                         input logic [11:0] ra, input logic [31:0] e, input string r);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = ra;
        sb_q.push_back('{exp: e, req: r});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic fire(input int leaf, input logic [31:0] bits);
        @(negedge clk);
        evt[leaf*32 +: 32] = bits;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic check_irq(input int exp, input string r);
        @(negedge clk);
        #1;
        n_vec++;
        if (irq_cnt != exp) begin
            n_bad++;
            $display("FAIL %s irq count: actual %0d expected %0d", r, irq_cnt, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h004, 32'hFFFF_FFFF, "R1 mask0");
        rd(12'h008, 32'h0, "R1 ident0");
        rd(12'h03C, 32'h0, "R1 enable3");
        rd(12'h100, 32'h0, "R1 master");
        check_irq(0, "R1");

        // R4 status while event held, mask all ones
        @(negedge clk);
        evt[31:0] = 32'h0000_0C00;
        @(negedge clk);
        rd_en = 1'b1; addr = 12'h000;
        sb_q.push_back('{exp: 32'h0000_0C00, req: "R4 status"});
        @(negedge clk);
        rd_en = 1'b0; evt = '0;
        rd(12'h008, 32'h0, "R2 masked drop");

        // R2 unmask and latch
        wr(12'h004, 32'h0);
        fire(0, 32'h0010_0008);
        rd(12'h008, 32'h0010_0008, "R2 latch");
        rd(12'h100, 32'h0, "R5 no enable");

        // R11 / R5 split low half
        wr_rd(12'h00C, 32'h0000_FFFF, 12'h100, 32'h0000_0001, "R11 enable low");
        check_irq(0, "R9 switch off");

        // R6 master write, R7 rising edge
        wr_rd(12'h100, 32'hFFFF_FFFF, 12'h100, 32'h8000_0001, "R6 master");
        check_irq(1, "R7 rise");

        // R5 upper half, R8 no re-pulse on enable write
        wr_rd(12'h00C, 32'hFFFF_FFFF, 12'h100, 32'h8000_0003, "R5 upper half");
        check_irq(1, "R8 no pulse on enable");

        // R8 new event re-pulses
        fire(0, 32'h0000_0020);
        check_irq(2, "R8 event");
        rd(12'h008, 32'h0010_0028, "R2 ident");

        // R3 write one to clear
        wr_rd(12'h008, 32'h0000_0008, 12'h008, 32'h0010_0020, "R3 w1c");
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h008; wdata = 32'h0000_0020;
        evt[31:0] = 32'h0000_0020;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(12'h008, 32'h0010_0020, "R3 event wins");
        check_irq(3, "R8 event with clear");
        wr_rd(12'h008, 32'hFFFF_FFFF, 12'h100, 32'h8000_0000, "R11 ident clear");

        // second leaves
        wr(12'h024, 32'h0);
        wr(12'h02C, 32'hFFFF_FFFF);
        fire(2, 32'h8000_0000);
        rd(12'h100, 32'h8002_0000, "R5 leaf2");
        check_irq(4, "R7 rise again");
        wr(12'h034, 32'h0);
        wr(12'h03C, 32'hFFFF_FFFF);
        fire(3, 32'h0000_0001);
        rd(12'h100, 32'h8006_0000, "R5 leaf3");
        check_irq(5, "R8 hold");

        // R9 switch off
        wr_rd(12'h100, 32'h7FFF_FFFF, 12'h100, 32'h0006_0000, "R6 summary kept");
        fire(2, 32'h0000_0002);
        check_irq(5, "R9 no delivery");

        // R10 unmapped
        rd(12'h0F0, 32'h0, "R10 unmapped");
        rd(12'h104, 32'h0, "R10 near master");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule